// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

This block is a port of general-purpose pins that all run on one system clock. Software configures each pin through a small register bus. A pin can be handed to an on-chip peripheral or kept as a plain GPIO. When it is a GPIO it can drive a value or be left undriven. Its input buffer can be gated off. It can raise an interrupt on a level or on an edge, with either polarity.

Every pin input passes through a fixed three-flop synchronizer. The delays are therefore exact:

- The readable input data follows the pin three cycles after the pin changes.
- A level interrupt asserts one cycle after that, four cycles in total.
- An edge interrupt is first captured in a sticky status bit and then registered onto the request line, five cycles in total.

The interrupt request is a single registered wire. It is the OR of every masked pin status and goes to a separate interrupt controller.

Top module: `gpio_port`

## Requirements
- R1: After reset, every control register reads 0: function enable, direction, input enable, output data, edge select, polarity and mask. The status register also reads 0, `pad_oe_o` is 0 and `irq_o` is 0.
- R2: With its function-enable bit clear, a pin's `pad_oe_o` bit equals its direction bit and its `pad_o` bit equals its output data bit. A write to output data appears on `pad_o` at the clock edge that takes the write, so the driven value can change on every cycle.
- R3: When a pin's input-enable bit is set, a change on `pad_i` is readable in the input data register (address 4) after exactly the third rising clock edge following the change, and not after the second.
- R4: With level mode (edge select bit 0), active-high polarity (polarity bit 0) and the mask bit set, `irq_o` rises after the fourth clock edge following the pin becoming active, and not after the third.
- R5: With edge mode (edge select bit 1), a qualifying edge sets the pin's status bit after the fourth clock edge. `irq_o` follows after the fifth edge when the mask bit is set. The status bit and the request stay set after the pin returns to its idle level.
- R6: Polarity bit 1 selects active-low in level mode and the falling edge in edge mode. With polarity 1, a rising edge does not set status.
- R7: Writing 1 to a status bit (address 8) clears it, and `irq_o` falls one edge later. Writing 0 leaves the bit set.
- R8: With a pin's input-enable bit clear, its input data bit reads 0 and the pin raises no interrupt. This holds even for active-low level mode, where the gated input of 0 would otherwise count as active.
- R9: With the function-enable bit set, `pad_o` and `pad_oe_o` come from `per_out_i` and `per_oe_i`, and `per_in_o` carries `pad_i`. With the bit clear, `per_in_o` is 0 and the peripheral outputs have no effect on the pad.
- R10: `irq_o` is a registered OR over all pins of (status bit AND mask bit). With the mask clear, status may be set while `irq_o` stays 0; setting the mask raises `irq_o` one edge after the write.
- R11: Level interrupts are not latched. The status register shows the live level hit from the synchronized input, and `irq_o` falls four edges after the pin goes inactive.
- R12: Register word addresses are: function enable 0, direction 1, input enable 2, output data 3, input data 4 (read-only), edge select 5, polarity 6, mask 7, status 8. Writable registers read back what was written. Writes to input data are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data, combinational on addr_i |
| pad_i | input | NPINS | Pin input levels |
| pad_o | output | NPINS | Pin output levels |
| pad_oe_o | output | NPINS | Pin output enables |
| per_out_i | input | NPINS | Peripheral output values |
| per_oe_i | input | NPINS | Peripheral output enables |
| per_in_o | output | NPINS | Pin levels passed to the peripheral |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts edges after each pin change and checks the cycle before and the cycle of each expected transition. A synchronizer one flop short or long would therefore show up as an input or interrupt arriving a cycle early or late.

It targets active-low level mode with the input buffer switched off. A design that gated only the data path would keep interrupting on the forced-zero input.

It also checks that a rising edge is ignored when the falling edge is selected, that writing 0 to status leaves the bit set, and that the request stays set after the pin goes idle. A design that tracked the pin, or cleared status on any write, would drop the request there.

Peripheral values are driven while the function-enable bit is clear. A leaky mux would put them on the pad or show the pin to the peripheral.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned SYNC_DEPTH = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_FUNC = 4'd0,
    RA_DIR  = 4'd1,
    RA_INEN = 4'd2,
    RA_OUT  = 4'd3,
    RA_IN   = 4'd4,
    RA_EDGE = 4'd5,
    RA_POL  = 4'd6,
    RA_MASK = 4'd7,
    RA_STAT = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      din_i,
  input  logic [W-1:0]      stat_i,
  output logic [W-1:0]      fer_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      inen_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      edge_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o
);
  logic [W-1:0] fer_q, dir_q, inen_q, out_q, edge_q, pol_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fer_q  <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      out_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_FUNC: fer_q  <= wdata_i;
        RA_DIR:  dir_q  <= wdata_i;
        RA_INEN: inen_q <= wdata_i;
        RA_OUT:  out_q  <= wdata_i;
        RA_EDGE: edge_q <= wdata_i;
        RA_POL:  pol_q  <= wdata_i;
        RA_MASK: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // write-1-to-clear strobe for status
  assign clr_o = (wr_en_i && addr_i == RA_STAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      RA_FUNC: rdata_o = fer_q;
      RA_DIR:  rdata_o = dir_q;
      RA_INEN: rdata_o = inen_q;
      RA_OUT:  rdata_o = out_q;
      RA_IN:   rdata_o = din_i;
      RA_EDGE: rdata_o = edge_q;
      RA_POL:  rdata_o = pol_q;
      RA_MASK: rdata_o = mask_q;
      RA_STAT: rdata_o = stat_i;
      default: rdata_o = '0;
    endcase
  end

  assign fer_o  = fer_q;
  assign dir_o  = dir_q;
  assign inen_o = inen_q;
  assign out_o  = out_q;
  assign edge_o = edge_q;
  assign pol_o  = pol_q;
  assign mask_o = mask_q;

  AST_READBACK_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_DIR) |=> (dir_o == $past(wdata_i))); // R12
endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
module gpio_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] inen_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] din_d, status_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit;
  logic         irq_q;

  assign rise     = din_i & ~din_d;
  assign fall     = ~din_i & din_d;
  // gate with input enable so a disabled pin cannot fire on its forced zero
  assign edge_hit = ((rise & ~pol_i) | (fall & pol_i)) & edge_i & inen_i;
  assign lvl_hit  = (din_i ^ pol_i) & ~edge_i & inen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_d    <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      din_d    <= din_i;
      status_q <= (status_q & ~clr_i) | edge_hit;
      irq_q    <= |((status_q | lvl_hit) & mask_i);
    end
  end

  assign stat_o = status_q | lvl_hit;
  assign irq_o  = irq_q;

  AST_STICKY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o); // R10
  AST_LEVEL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lvl_hit & mask_i)) |=> irq_o); // R4
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  input  logic [NPINS-1:0]  per_out_i,
  input  logic [NPINS-1:0]  per_oe_i,
  output logic [NPINS-1:0]  per_in_o,
  output logic              irq_o
);
  logic [NPINS-1:0] fer, dir, inen, out_q, edge_sel, pol, mask, clr;
  logic [NPINS-1:0] pin_gated, din_q, stat;

  gpio_regs #(.W(NPINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .din_i   (din_q),
    .stat_i  (stat),
    .fer_o   (fer),
    .dir_o   (dir),
    .inen_o  (inen),
    .out_o   (out_q),
    .edge_o  (edge_sel),
    .pol_o   (pol),
    .mask_o  (mask),
    .clr_o   (clr)
  );

  assign pin_gated = pad_i & inen;

  gpio_sync #(.W(NPINS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_gated),
    .q_o    (din_q)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_q),
    .inen_i (inen),
    .edge_i (edge_sel),
    .pol_i  (pol),
    .mask_i (mask),
    .clr_i  (clr),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign pad_o[g]    = fer[g] ? per_out_i[g] : out_q[g];
    assign pad_oe_o[g] = fer[g] ? per_oe_i[g]  : dir[g];
    assign per_in_o[g] = fer[g] & pad_i[g];
  end

  // edges seen since reset, saturating; qualifies the latency check
  logic [1:0] vld_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             vld_cnt <= 2'd0;
    else if (vld_cnt != 2'd3) vld_cnt <= vld_cnt + 2'd1;
  end

  AST_IN_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_cnt == 2'd3) |-> (din_q == $past(pad_i & inen, 3))); // R3
  AST_OUT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_OUT) |=> (((pad_o ^ $past(wdata_i)) & ~fer) == '0)); // R2
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int unsigned NP = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [3:0]    addr;
  logic [NP-1:0] wdata, rdata, pin, pad_o, pad_oe, per_out, per_oe, per_in;
  logic          irq;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  gpio_port #(.NPINS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pin), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .per_out_i(per_out), .per_oe_i(per_oe),
    .per_in_o(per_in), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    pin = '0; per_out = '0; per_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NP-1:0] v;
    do_reset();
    pin = '1;
    settle();
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), 32'(v), 32'h0);
    end
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_output();
    do_reset();
    wr(4'd1, 16'h00FF);
    wr(4'd3, 16'hA5A5);
    chk("R2 oe follows dir", 32'(pad_oe), 32'h00FF);
    chk("R2 pad follows out", 32'(pad_o), 32'hA5A5);
    per_out = '1; per_oe = '1;
    #1;
    chk("R9 per_out ignored", 32'(pad_o), 32'hA5A5);
    chk("R9 per_oe ignored", 32'(pad_oe), 32'h00FF);
    wr_en = 1'b1; addr = 4'd3;
    for (int i = 1; i <= 3; i++) begin
      wdata = 16'(i);
      @(negedge clk);
      chk("R2 change every cycle", 32'(pad_o), 32'(i));
    end
    wr_en = 1'b0;
  endtask

  task automatic t_periph();
    do_reset();
    wr(4'd1, 16'hFF00);
    wr(4'd3, 16'h0000);
    wr(4'd0, 16'h000F);
    per_out = 16'h0005; per_oe = 16'h0003; pin = 16'h00F9;
    #1;
    chk("R9 pad from peripheral", 32'(pad_o), 32'h0005);
    chk("R9 oe from peripheral", 32'(pad_oe), 32'hFF03);
    chk("R9 per_in only on enabled pins", 32'(per_in), 32'h0009);
  endtask

  task automatic t_input();
    logic [NP-1:0] v;
    do_reset();
    wr(4'd2, 16'hFFFF);
    pin = 16'h5A3C;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      rd(4'd4, v);
      if (k == 2) chk("R3 not yet after 2 edges", 32'(v), 32'h0);
      if (k == 3) chk("R3 visible after 3 edges", 32'(v), 32'h5A3C);
    end
    pin = 16'h0F0F;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      rd(4'd4, v);
      if (k == 2) chk("R3 second pattern early", 32'(v), 32'h5A3C);
      if (k == 3) chk("R3 second pattern", 32'(v), 32'h0F0F);
    end
  endtask

  task automatic t_level();
    logic [NP-1:0] v;
    do_reset();
    wr(4'd2, 16'h0001);
    wr(4'd7, 16'h0001);
    settle();
    pin = 16'h0001;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) begin
        chk("R4 irq low after 3 edges", 32'(irq), 32'h0);
        rd(4'd8, v);
        chk("R11 live status", 32'(v), 32'h1);
      end
      if (k == 4) chk("R4 irq after 4 edges", 32'(irq), 32'h1);
    end
    pin = 16'h0000;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk("R11 irq held 3 edges", 32'(irq), 32'h1);
      if (k == 4) begin
        chk("R11 irq drops after 4 edges", 32'(irq), 32'h0);
        rd(4'd8, v);
        chk("R11 status not latched", 32'(v), 32'h0);
      end
    end
  endtask

  task automatic t_edge();
    logic [NP-1:0] v;
    do_reset();
    wr(4'd5, 16'h0002);
    wr(4'd2, 16'h0002);
    wr(4'd7, 16'h0002);
    settle();
    pin = 16'h0002;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      rd(4'd8, v);
      if (k == 3) chk("R5 status early", 32'(v), 32'h0);
      if (k == 4) begin
        chk("R5 status after 4 edges", 32'(v), 32'h2);
        chk("R5 irq low after 4 edges", 32'(irq), 32'h0);
      end
      if (k == 5) chk("R5 irq after 5 edges", 32'(irq), 32'h1);
    end
    pin = 16'h0000;
    settle();
    rd(4'd8, v);
    chk("R5 status latched", 32'(v), 32'h2);
    chk("R5 irq latched", 32'(irq), 32'h1);
    wr(4'd8, 16'h0000);
    rd(4'd8, v);
    chk("R7 write 0 keeps status", 32'(v), 32'h2);
    wr(4'd8, 16'h0002);
    rd(4'd8, v);
    chk("R7 write 1 clears", 32'(v), 32'h0);
    @(negedge clk);
    chk("R7 irq falls", 32'(irq), 32'h0);
  endtask

  task automatic t_pol();
    logic [NP-1:0] v;
    do_reset();
    pin = 16'h0004;
    wr(4'd6, 16'h000C);
    wr(4'd2, 16'h000C);
    settle();
    wr(4'd5, 16'h0008);
    pin = 16'h000C;
    settle();
    rd(4'd8, v);
    chk("R6 rising ignored when falling selected", 32'(v & 16'h8), 32'h0);
    wr(4'd7, 16'h0004);
    @(negedge clk);
    chk("R6 active-low idle", 32'(irq), 32'h0);
    pin = 16'h0008;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk("R6 level low early", 32'(irq), 32'h0);
      if (k == 4) chk("R6 active-low irq", 32'(irq), 32'h1);
    end
    pin = 16'h0000;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      rd(4'd8, v);
      if (k == 3) chk("R6 falling early", 32'(v & 16'h8), 32'h0);
      if (k == 4) chk("R6 falling edge latched", 32'(v & 16'h8), 32'h8);
    end
  endtask

  task automatic t_inen();
    logic [NP-1:0] v;
    do_reset();
    wr(4'd6, 16'h0004);
    pin = 16'h0080;
    wr(4'd2, 16'h0084);
    settle();
    wr(4'd7, 16'h0004);
    repeat (2) @(negedge clk);
    chk("R8 enabled low pin fires", 32'(irq), 32'h1);
    rd(4'd4, v);
    chk("R8 enabled input reads", 32'(v), 32'h0080);
    wr(4'd2, 16'h0000);
    settle();
    rd(4'd4, v);
    chk("R8 disabled input reads 0", 32'(v), 32'h0);
    chk("R8 disabled pin no irq", 32'(irq), 32'h0);
    rd(4'd8, v);
    chk("R8 disabled status clear", 32'(v), 32'h0);
  endtask

  task automatic t_mask();
    logic [NP-1:0] v;
    do_reset();
    wr(4'd5, 16'h0002);
    wr(4'd2, 16'h0002);
    pin = 16'h0002;
    settle();
    rd(4'd8, v);
    chk("R10 status set while masked", 32'(v), 32'h2);
    chk("R10 masked irq low", 32'(irq), 32'h0);
    wr(4'd7, 16'h0002);
    chk("R10 irq registered", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R10 irq after unmask", 32'(irq), 32'h1);
    wr(4'd7, 16'h0001);
    @(negedge clk);
    chk("R10 other mask bit only", 32'(irq), 32'h0);
  endtask

  task automatic t_map();
    logic [NP-1:0] v;
    do_reset();
    rd(4'd15, v);
    chk("R12 unmapped 15", 32'(v), 32'h0);
    rd(4'd9, v);
    chk("R12 unmapped 9", 32'(v), 32'h0);
    foreach (v[i]) ;
    for (int a = 0; a <= 7; a++) begin
      if (a == 4) continue;
      wr(4'(a), 16'h1230 + 16'(a));
      rd(4'(a), v);
      chk($sformatf("R12 readback %0d", a), 32'(v), 32'h1230 + 32'(a));
    end
    do_reset();
    wr(4'd2, 16'hFFFF);
    pin = 16'h1234;
    settle();
    wr(4'd4, 16'hFFFF);
    rd(4'd4, v);
    chk("R12 input data write ignored", 32'(v), 32'h1234);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_output();
    t_periph();
    t_input();
    t_level();
    t_edge();
    t_pol();
    t_inen();
    t_mask();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule